// File: doc/BRIEF.md
# Floating-Point Multi-Register Transfer Sequencer

This block turns one floating-point load or store instruction that moves one to four registers into a fixed series of micro-operations. The register count sits in two separate instruction bits. Each register becomes a group of three consecutive transfer micro-ops. An optional base-update micro-op follows the groups and adds or subtracts the word-scaled displacement on the base register. The block takes the decoded instruction fields with a valid/ready handshake and emits the micro-ops one at a time on a second valid/ready handshake.

Back-pressure rules: an instruction is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while no sequence is in progress, so while the block is busy, the offered fields have no effect. A micro-op moves on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output field holds its value. The block drops `out_valid` on the edge that takes the micro-op flagged last. A new instruction can be taken on the next edge after that, at the earliest.

Top module: `fpx_sequencer`

## Requirements
- R1: The register count is `{in_cnt_hi, in_cnt_lo}` read as a 2-bit number, where 01, 10 and 11 mean one, two and three registers and 00 means four.
- R2: Each register expands into three micro-ops with `out_slot` equal to 0, 1 and 2 in that order, all carrying the same `out_reg`.
- R3: An instruction issues exactly 3 × count micro-ops, plus one more when `in_wb` is set. After the last of them, `out_valid` is low.
- R4: Every transfer micro-op carries `out_off` = `in_imm` × 4 when `in_pre` is set, and 0 otherwise.
- R5: With `in_wb` set, the final micro-op is a base update. Its kind is 2 (add) when `in_up` is 1 and 3 (subtract) when `in_up` is 0. It has `out_off` = `in_imm` × 4, `out_reg` = 0 and `out_slot` = 0.
- R6: `out_last` is 1 on the final micro-op of an instruction and 0 on every other one.
- R7: The first group uses register `in_freg`. Each later group uses the previous register plus one, modulo 8.
- R8: Transfer micro-ops have kind 1 when `in_load` is 1 and kind 0 (store) when `in_load` is 0. Every micro-op carries `in_base` on `out_base`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and every output field stay unchanged on the next cycle.
- R10: `in_ready` is low whenever a sequence is in progress. Fields offered with `in_valid` during that time have no effect on the stream.
- R11: A synchronous active-high `rst` abandons any sequence. On the cycle after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction fields are offered |
| in_ready | output | 1 | Block is idle and will take an instruction |
| in_cnt_hi | input | 1 | Upper count bit |
| in_cnt_lo | input | 1 | Lower count bit |
| in_imm | input | 8 | Word displacement |
| in_pre | input | 1 | Pre-index: transfers use the displacement |
| in_up | input | 1 | Base update adds (1) or subtracts (0) |
| in_wb | input | 1 | Append a base-update micro-op |
| in_load | input | 1 | Load (1) or store (0) |
| in_freg | input | 3 | First floating-point register |
| in_base | input | 4 | Base register number |
| out_valid | output | 1 | Micro-op is offered |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 2 | 0 store, 1 load, 2 base add, 3 base subtract |
| out_reg | output | 3 | Floating-point register of the group |
| out_slot | output | 2 | Position within the group of three |
| out_off | output | 10 | Byte offset |
| out_base | output | 4 | Base register number |
| out_last | output | 1 | Final micro-op of the instruction |

## Verification
The edge that takes the last micro-op can coincide with the next instruction being offered on the input side. Then the completing handshake and the input handshake fall in the same cycle. The bench raises `in_valid` with the next instruction's fields in exactly that cycle. It checks that `in_ready` is low there, that the instruction is taken on the following edge, and that its stream starts complete and undisturbed. A similar collision is provoked by offering a different instruction in the middle of a stalled stream. The bench then compares every later micro-op against the model of the original instruction.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    K_STORE = 2'd0,
    K_LOAD  = 2'd1,
    K_BADD  = 2'd2,
    K_BSUB  = 2'd3
  } uop_kind_e;
endpackage

// File: rtl/fpx_decode.sv
module fpx_decode #(
  parameter int IMM_W = 8,
  localparam int OFF_W = IMM_W + 2
) (
  input  logic             cnt_hi,
  input  logic             cnt_lo,
  input  logic [IMM_W-1:0] imm,
  input  logic             pre,
  output logic [1:0]       cnt_m1,
  output logic [OFF_W-1:0] disp,
  output logic [OFF_W-1:0] xfer_off
);
  // 2-bit wrap makes code 00 decode to count-1 = 3, i.e. four registers
  always_comb begin
    cnt_m1   = {cnt_hi, cnt_lo} - 2'd1;
    disp     = {imm, 2'b00};
    xfer_off = pre ? {imm, 2'b00} : '0;
  end
endmodule

// File: rtl/fpx_seq.sv
module fpx_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] cnt_m1,
  input  logic       wb,
  input  logic       adv,
  output logic       busy,
  output logic [1:0] grp,
  output logic [1:0] slot,
  output logic       wb_phase,
  output logic       last
);
  logic [1:0] cnt_m1_q;
  logic       wb_q;
  logic       grp_end;

  always_comb begin
    grp_end = (slot == 2'd2) && (grp == cnt_m1_q);
    last    = busy && (wb_phase || (grp_end && !wb_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      grp      <= '0;
      slot     <= '0;
      wb_phase <= 1'b0;
      cnt_m1_q <= '0;
      wb_q     <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        grp      <= '0;
        slot     <= '0;
        wb_phase <= 1'b0;
        cnt_m1_q <= cnt_m1;
        wb_q     <= wb;
      end
    end else if (adv) begin
      if (wb_phase) begin
        busy     <= 1'b0;
        wb_phase <= 1'b0;
      end else if (slot != 2'd2) begin
        slot <= slot + 2'd1;
      end else begin
        slot <= '0;
        if (grp == cnt_m1_q) begin
          if (wb_q) wb_phase <= 1'b1;
          else      busy     <= 1'b0;
        end else begin
          grp <= grp + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/fpx_sequencer.sv
module fpx_sequencer #(
  parameter int IMM_W  = 8,
  parameter int FREG_W = 3,
  parameter int BASE_W = 4,
  localparam int OFF_W = IMM_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_cnt_hi,
  input  logic              in_cnt_lo,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic              in_pre,
  input  logic              in_up,
  input  logic              in_wb,
  input  logic              in_load,
  input  logic [FREG_W-1:0] in_freg,
  input  logic [BASE_W-1:0] in_base,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [FREG_W-1:0] out_reg,
  output logic [1:0]        out_slot,
  output logic [OFF_W-1:0]  out_off,
  output logic [BASE_W-1:0] out_base,
  output logic              out_last
);
  import fpx_pkg::*;

  logic [1:0]        dec_cnt_m1;
  logic [OFF_W-1:0]  dec_disp, dec_xoff;
  logic              busy, wb_phase, seq_last, take;
  logic [1:0]        grp, slot;

  logic              load_q, up_q;
  logic [FREG_W-1:0] freg_q;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  disp_q, xoff_q;

  fpx_decode #(.IMM_W(IMM_W)) u_dec (
    .cnt_hi   (in_cnt_hi),
    .cnt_lo   (in_cnt_lo),
    .imm      (in_imm),
    .pre      (in_pre),
    .cnt_m1   (dec_cnt_m1),
    .disp     (dec_disp),
    .xfer_off (dec_xoff)
  );

  assign in_ready = !busy;
  assign take     = in_valid && !busy;

  fpx_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (take),
    .cnt_m1   (dec_cnt_m1),
    .wb       (in_wb),
    .adv      (out_ready),
    .busy     (busy),
    .grp      (grp),
    .slot     (slot),
    .wb_phase (wb_phase),
    .last     (seq_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= 1'b0;
      up_q   <= 1'b0;
      freg_q <= '0;
      base_q <= '0;
      disp_q <= '0;
      xoff_q <= '0;
    end else if (take) begin
      load_q <= in_load;
      up_q   <= in_up;
      freg_q <= in_freg;
      base_q <= in_base;
      disp_q <= dec_disp;
      xoff_q <= dec_xoff;
    end
  end

  always_comb begin
    out_valid = busy;
    out_kind  = K_STORE;
    out_reg   = '0;
    out_slot  = '0;
    out_off   = '0;
    out_base  = '0;
    out_last  = 1'b0;
    if (busy) begin
      out_base = base_q;
      out_last = seq_last;
      if (wb_phase) begin
        out_kind = up_q ? K_BADD : K_BSUB;
        out_off  = disp_q;
      end else begin
        out_kind = load_q ? K_LOAD : K_STORE;
        out_reg  = freg_q + FREG_W'(grp);
        out_slot = slot;
        out_off  = xoff_q;
      end
    end
  end
endmodule

// File: rtl/fpx_sequencer_chk.sv
module fpx_sequencer_chk #(
  parameter int FREG_W = 3,
  parameter int BASE_W = 4,
  parameter int OFF_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_kind,
  input logic [FREG_W-1:0] out_reg,
  input logic [1:0]        out_slot,
  input logic [OFF_W-1:0]  out_off,
  input logic [BASE_W-1:0] out_base,
  input logic              out_last
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_reg)
      && $stable(out_slot) && $stable(out_off) && $stable(out_base) && $stable(out_last))); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R10
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid); // R6
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_slot != 2'd3)); // R2
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last && out_slot != 2'd2 && !out_kind[1])
      |=> (out_slot == $past(out_slot) + 2'd1)); // R2
  AST_UPDATE_FINAL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind[1]) |-> out_last); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready)); // R11
endmodule

bind fpx_sequencer fpx_sequencer_chk #(
  .FREG_W(FREG_W), .BASE_W(BASE_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_kind(out_kind), .out_reg(out_reg),
  .out_slot(out_slot), .out_off(out_off), .out_base(out_base),
  .out_last(out_last)
);

// File: tb/test_fpx_sequencer.sv
module test_fpx_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_cnt_hi = 1'b0, in_cnt_lo = 1'b0;
  logic [7:0] in_imm = '0;
  logic       in_pre = 1'b0, in_up = 1'b0, in_wb = 1'b0, in_load = 1'b0;
  logic [2:0] in_freg = '0;
  logic [3:0] in_base = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [1:0] out_kind;
  logic [2:0] out_reg;
  logic [1:0] out_slot;
  logic [9:0] out_off;
  logic [3:0] out_base;
  logic       out_last;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fpx_sequencer i_fpx_sequencer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cnt_hi(in_cnt_hi), .in_cnt_lo(in_cnt_lo), .in_imm(in_imm),
    .in_pre(in_pre), .in_up(in_up), .in_wb(in_wb), .in_load(in_load),
    .in_freg(in_freg), .in_base(in_base), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_reg(out_reg),
    .out_slot(out_slot), .out_off(out_off), .out_base(out_base),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pack_out();
    return {out_kind, out_reg, out_slot, out_off, out_base, out_last};
  endfunction

  task automatic drive(input bit hi, input bit lo, input int imm, input bit pre,
                       input bit up, input bit wb, input bit ld, input int fr,
                       input int base);
    in_valid = 1'b1; in_cnt_hi = hi; in_cnt_lo = lo; in_imm = imm[7:0];
    in_pre = pre; in_up = up; in_wb = wb; in_load = ld;
    in_freg = fr[2:0]; in_base = base[3:0];
  endtask

  // Starts and ends just after a falling edge.
  task automatic run_seq(input bit hi, input bit lo, input int imm, input bit pre,
                         input bit up, input bit wb, input bit ld, input int fr,
                         input int base, input bit stall, input bit intrude,
                         input bit arm_next, input string tag);
    int n, total, k, cyc, prev;
    bit prev_stall;
    n = ({hi, lo} == 2'b00) ? 4 : int'({hi, lo});            // R1
    total = 3 * n + (wb ? 1 : 0);                           // R3
    drive(hi, lo, imm, pre, up, wb, ld, fr, base);
    chk(in_ready === 1'b1, "R10 idle ready", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    k = 0; cyc = 0; prev_stall = 0; prev = 0;
    while (k < total && cyc < 200) begin
      int g, s, ek, er, es, eo, el, exp_v;
      bit rdy;
      rdy = stall ? (cyc % 3 != 2) : 1'b1;
      out_ready = rdy;
      if (k < 3 * n) begin
        g = k / 3; s = k % 3;
        ek = ld ? 1 : 0;                                    // R8
        er = (fr + g) & 7;                                  // R7
        es = s;                                             // R2
        eo = pre ? imm * 4 : 0;                             // R4
      end else begin
        ek = up ? 2 : 3; er = 0; es = 0; eo = imm * 4;      // R5
      end
      el = (k == total - 1) ? 1 : 0;                        // R6
      exp_v = {ek[1:0], er[2:0], es[1:0], eo[9:0], base[3:0], el[0]};
      chk(out_valid === 1'b1 && pack_out() == exp_v,
          $sformatf("%s uop%0d R2/R4/R5/R6/R7/R8", tag, k), pack_out(), exp_v);
      if (prev_stall)
        chk(pack_out() == prev, "R9 hold under stall", pack_out(), prev);
      if (intrude && k == 1) begin
        drive(~hi, lo, imm + 5, ~pre, ~up, ~wb, ~ld, fr + 3, base + 1);
        chk(in_ready === 1'b0, "R10 busy ready", int'(in_ready), 0);
      end
      if (arm_next && rdy && k == total - 1) begin
        in_valid = 1'b1;
        chk(in_ready === 1'b0, "R10 ready at last", int'(in_ready), 0);
      end
      prev_stall = !rdy;
      prev = pack_out();
      @(posedge clk);
      if (rdy) k++;
      cyc++;
      @(negedge clk);
      if (!arm_next) in_valid = 1'b0;
    end
    out_ready = 1'b1;
    chk(k == total, {tag, " R3 count"}, k, total);
    chk(out_valid === 1'b0, {tag, " R3 idle after last"}, int'(out_valid), 0);
    chk(in_ready === 1'b1, {tag, " R10 ready after last"}, int'(in_ready), 1);
  endtask

  task automatic t_reset_state();
    chk(out_valid === 1'b0, "R11 reset valid", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R11 reset ready", int'(in_ready), 1);
  endtask

  task automatic t_single();
    run_seq(0, 1, 8'h11, 0, 1, 0, 0, 2, 5, 0, 0, 0, "single store R1");
  endtask

  task automatic t_four_wrap();
    run_seq(0, 0, 8'h3c, 1, 1, 1, 1, 6, 9, 0, 0, 0, "four wrap R7");
  endtask

  task automatic t_two_sub();
    run_seq(1, 0, 8'hff, 1, 0, 1, 0, 1, 13, 0, 0, 0, "two sub R5");
  endtask

  task automatic t_three_stall_intrude();
    run_seq(1, 1, 8'h07, 0, 0, 1, 1, 4, 2, 1, 1, 0, "three stall R9");
  endtask

  task automatic t_overlap();
    run_seq(0, 1, 8'h02, 1, 1, 1, 1, 7, 3, 0, 0, 1, "overlap first R10");
    chk(in_ready === 1'b1 && in_valid === 1'b1, "R10 offer kept", int'(in_ready), 1);
    run_seq(0, 1, 8'h02, 1, 1, 1, 1, 7, 3, 0, 0, 0, "overlap second R10");
  endtask

  task automatic t_reset_mid();
    drive(0, 0, 8'h20, 1, 1, 1, 1, 0, 4);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk(out_valid === 1'b0, "R11 mid reset valid", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R11 mid reset ready", int'(in_ready), 1);
    run_seq(1, 0, 8'h01, 0, 0, 0, 0, 5, 1, 0, 0, 0, "after reset R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_single();
    t_four_wrap();
    t_two_sub();
    t_three_stall_intrude();
    t_overlap();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule